// File: doc/BRIEF.md
# Quad-Width Byte-Register ALU

This block gives an 8-bit core a 32-bit data path without adding a 32-bit register. The core's four byte registers are viewed together as one quad value Q. Each accepted operation reads Q, a 32-bit memory operand, or both, and computes a 32-bit result. It then writes the result either back across the four byte registers or out on a memory-result port. It also updates the negative, zero, carry and overflow flags.

Operations follow a single-cycle registered timing. An operation presented with `op_valid` high is applied at the next rising clock edge, and its effects are visible on the outputs after that edge. The block does not generate addresses, sequence the bus or decode opcodes. The surrounding core supplies an operation code, a flag that chooses a memory target, and the operand it has already fetched.

Top module: `quad_alu`

## Requirements
- R1: Q is assembled from the byte registers as {reg_z, reg_y, reg_x, reg_a}, so reg_a holds bits 7:0 and reg_z holds bits 31:24; a load splits its operand back across the four registers in the same order.
- R2: Load (op_code 0) copies mem_rdata into Q. It sets N to bit 31 and Z to 1 only when all 32 bits are zero, and leaves C and V unchanged.
- R3: Store (op_code 1) drives Q onto mem_wdata with mem_we high for exactly one cycle and leaves the byte registers unchanged. Unlike an 8-bit store, it overwrites N and Z from the stored value.
- R4: Compare (op_code 2) computes Q minus mem_rdata. C is set when Q is greater than or equal to the operand as unsigned numbers, Z is set on equality and N takes bit 31 of the difference. No register and no V changes.
- R5: Add with carry (op_code 3) sets Q to Q + mem_rdata + C. C becomes the carry out of bit 31 and V the signed overflow at bit 31.
- R6: Subtract with carry (op_code 4) sets Q to Q - mem_rdata - (1 - C). C becomes 1 when no borrow occurs and V the signed overflow.
- R7: AND, OR and EOR (op_codes 5, 6, 7) combine Q with mem_rdata bitwise into Q. They update N and Z and leave C and V unchanged.
- R8: Shift left (op_code 8) moves a 0 into bit 0 and bit 31 into C. Shift right (op_code 9) moves a 0 into bit 31 and bit 0 into C.
- R9: Rotate left (op_code 10) and rotate right (op_code 11) pass through C across all 32 bits: the old C enters the vacated end and the bit leaving the other end becomes the new C.
- R10: Increment (op_code 12) and decrement (op_code 13) wrap modulo 2^32. They update only N and Z.
- R11: For op_codes 8 to 13 with use_mem high, the operand is mem_rdata. The result goes out on mem_wdata with mem_we for one cycle, the flags update as for the register form, and the byte registers keep their values. For every other op_code, use_mem has no effect.
- R12: A cycle with op_valid low, or with op_code 14 or 15, changes no register and no flag and leaves mem_we low.
- R13: While rst_n is low, all byte registers, all four flags and mem_we are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select (see requirements) |
| use_mem | input | 1 | Read-modify-write targets the memory operand |
| mem_rdata | input | 32 | Fetched 32-bit memory operand |
| reg_a | output | 8 | Byte register holding Q bits 7:0 |
| reg_x | output | 8 | Byte register holding Q bits 15:8 |
| reg_y | output | 8 | Byte register holding Q bits 23:16 |
| reg_z | output | 8 | Byte register holding Q bits 31:24 |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| mem_wdata | output | 32 | Result bound for memory |
| mem_wr | output | 1 | One-cycle memory write strobe |

## Verification
Two functions land on the same clock edge here. The first is the memory-result write, on a store or a read-modify-write with use_mem set. The second is the flag update, which a store also performs even though an 8-bit store would not. The stimulus table sets the flags to a known pattern with a compare and then issues a store. It also runs shifts, rotates and steps on memory operands while Q holds a different value. Each such step is judged by checking mem_wdata, the write strobe, the new N/Z/C values and the unchanged byte registers together, one cycle after the operation.

// File: rtl/quad_alu_pkg.sv
package quad_alu_pkg;

   typedef enum logic [3:0] {
      QOP_LOAD  = 4'd0,
      QOP_STORE = 4'd1,
      QOP_CMP   = 4'd2,
      QOP_ADC   = 4'd3,
      QOP_SBC   = 4'd4,
      QOP_AND   = 4'd5,
      QOP_OR    = 4'd6,
      QOP_EOR   = 4'd7,
      QOP_SHL   = 4'd8,
      QOP_SHR   = 4'd9,
      QOP_ROL   = 4'd10,
      QOP_ROR   = 4'd11,
      QOP_INC   = 4'd12,
      QOP_DEC   = 4'd13
   } quad_op_e;

   typedef struct packed {
      logic neg;
      logic zero;
      logic carry;
      logic ovf;
   } quad_flags_t;

   localparam int unsigned QOP_LAST = 13;

endpackage

// File: rtl/quad_addsub.sv
module quad_addsub #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned NUM_BYTES = 4,
   localparam int unsigned WIDTH    = BYTE_W * NUM_BYTES
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);

   generate
      if (BYTE_W < 1 || NUM_BYTES < 1) begin : g_bad_cfg
         $error("quad_addsub: slice width and slice count must be positive");
      end
   endgenerate

   logic [NUM_BYTES:0] chain;
   assign chain[0] = cin;

   // byte-sliced carry chain, one adder per register byte
   generate
      for (genvar s = 0; s < NUM_BYTES; s++) begin : g_slice
         logic [BYTE_W:0] part;
         assign part = {1'b0, opa[s*BYTE_W +: BYTE_W]}
                     + {1'b0, opb[s*BYTE_W +: BYTE_W]}
                     + {{BYTE_W{1'b0}}, chain[s]};
         assign sum[s*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
         assign chain[s+1]              = part[BYTE_W];
      end
   endgenerate

   assign cout = chain[NUM_BYTES];
   assign ovf  = (opa[WIDTH-1] == opb[WIDTH-1]) && (sum[WIDTH-1] != opa[WIDTH-1]);

endmodule

// File: rtl/quad_shifter.sv
module quad_shifter #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] val,
   input  logic             cin,
   input  logic [1:0]       mode,   // 0 shl, 1 shr, 2 rol, 3 ror
   output logic [WIDTH-1:0] res,
   output logic             cout
);

   generate
      if (WIDTH < 2) begin : g_bad_cfg
         $error("quad_shifter: width must be at least 2");
      end
   endgenerate

   logic fill;

   always_comb begin
      fill = mode[1] ? cin : 1'b0;
      if (mode[0]) begin
         res  = {fill, val[WIDTH-1:1]};
         cout = val[0];
      end else begin
         res  = {val[WIDTH-2:0], fill};
         cout = val[WIDTH-1];
      end
   end

endmodule

// File: rtl/quad_byte_regs.sv
module quad_byte_regs #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned NUM_BYTES = 4,
   localparam int unsigned WIDTH    = BYTE_W * NUM_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_val,
   output logic [WIDTH-1:0] q_view
);

   // separate byte registers; the wide value exists only as wiring
   generate
      for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
         logic [BYTE_W-1:0] breg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     breg <= '0;
            else if (wr_en) breg <= wr_val[b*BYTE_W +: BYTE_W];
         end
         assign q_view[b*BYTE_W +: BYTE_W] = breg;
      end
   endgenerate

endmodule

// File: rtl/quad_alu.sv
module quad_alu
   import quad_alu_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NREG  = 4,
   localparam int unsigned QW    = BYTE_W * NREG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic              use_mem,
   input  logic [QW-1:0]     mem_rdata,
   output logic [BYTE_W-1:0] reg_a,
   output logic [BYTE_W-1:0] reg_x,
   output logic [BYTE_W-1:0] reg_y,
   output logic [BYTE_W-1:0] reg_z,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v,
   output logic [QW-1:0]     mem_wdata,
   output logic              mem_wr
);

   generate
      if (BYTE_W < 2) begin : g_bad_cfg
         $error("quad_alu: byte width must be at least 2");
      end
   endgenerate

   logic [QW-1:0] q_cur;
   logic          known_op;
   logic          rmw_op;
   logic [QW-1:0] tgt;
   quad_flags_t   flg, flg_nx;

   assign known_op = (op_code <= 4'(QOP_LAST));
   assign rmw_op   = (op_code >= QOP_SHL) && (op_code <= QOP_DEC);
   assign tgt      = (rmw_op && use_mem) ? mem_rdata : q_cur;

   // adder operand steering
   logic [QW-1:0] add_a, add_b, add_sum;
   logic          add_cin, add_cout, add_ovf;

   always_comb begin
      add_a   = q_cur;
      add_b   = mem_rdata;
      add_cin = flg.carry;
      unique case (op_code)
         QOP_SBC: add_b = ~mem_rdata;
         QOP_CMP: begin add_b = ~mem_rdata; add_cin = 1'b1; end
         QOP_INC: begin add_a = tgt; add_b = '0; add_cin = 1'b1; end
         QOP_DEC: begin add_a = tgt; add_b = '1; add_cin = 1'b0; end
         default: ;
      endcase
   end

   quad_addsub #(.BYTE_W(BYTE_W), .NUM_BYTES(NREG)) u_addsub (
      .opa  (add_a),
      .opb  (add_b),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout),
      .ovf  (add_ovf)
   );

   logic [QW-1:0] sh_res;
   logic          sh_cout;

   quad_shifter #(.WIDTH(QW)) u_shift (
      .val  (tgt),
      .cin  (flg.carry),
      .mode (op_code[1:0]),
      .res  (sh_res),
      .cout (sh_cout)
   );

   // result select and flag derivation
   logic [QW-1:0] res;
   logic          to_q, to_mem;

   always_comb begin
      res    = q_cur;
      to_q   = 1'b0;
      to_mem = 1'b0;
      flg_nx = flg;
      unique case (op_code)
         QOP_LOAD:  begin res = mem_rdata; to_q = 1'b1; end
         QOP_STORE: begin res = q_cur; to_mem = 1'b1; end
         QOP_CMP:   begin res = add_sum; flg_nx.carry = add_cout; end
         QOP_ADC, QOP_SBC: begin
            res = add_sum; to_q = 1'b1;
            flg_nx.carry = add_cout;
            flg_nx.ovf   = add_ovf;
         end
         QOP_AND: begin res = q_cur & mem_rdata; to_q = 1'b1; end
         QOP_OR:  begin res = q_cur | mem_rdata; to_q = 1'b1; end
         QOP_EOR: begin res = q_cur ^ mem_rdata; to_q = 1'b1; end
         QOP_SHL, QOP_SHR, QOP_ROL, QOP_ROR: begin
            res = sh_res; flg_nx.carry = sh_cout;
            to_q = !use_mem; to_mem = use_mem;
         end
         QOP_INC, QOP_DEC: begin
            res = add_sum;
            to_q = !use_mem; to_mem = use_mem;
         end
         default: ;
      endcase
      flg_nx.neg  = res[QW-1];
      flg_nx.zero = (res == '0);
   end

   logic accept;
   assign accept = op_valid && known_op;

   quad_byte_regs #(.BYTE_W(BYTE_W), .NUM_BYTES(NREG)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (accept && to_q),
      .wr_val (res),
      .q_view (q_cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flg       <= '0;
         mem_wr    <= 1'b0;
         mem_wdata <= '0;
      end else begin
         mem_wr <= accept && to_mem;
         if (accept)           flg       <= flg_nx;
         if (accept && to_mem) mem_wdata <= res;
      end
   end

   assign reg_a  = q_cur[0*BYTE_W +: BYTE_W];
   assign reg_x  = q_cur[1*BYTE_W +: BYTE_W];
   assign reg_y  = q_cur[2*BYTE_W +: BYTE_W];
   assign reg_z  = q_cur[3*BYTE_W +: BYTE_W];
   assign flag_n = flg.neg;
   assign flag_z = flg.zero;
   assign flag_c = flg.carry;
   assign flag_v = flg.ovf;

   AST_MEM_RMW_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && use_mem && op_code >= 4'd8 && op_code <= 4'd13) |=> $stable(q_cur)); // R11

   AST_WRITE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(op_valid && (op_code == 4'd1 ||
                 (use_mem && op_code >= 4'd8 && op_code <= 4'd13)))); // R11

   AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid || op_code >= 4'd14) |=> ($stable(q_cur) && $stable(flg) && !mem_wr)); // R12

   AST_CMP_KEEPS_Q_V: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd2) |=> ($stable(q_cur) && $stable(flag_v))); // R4

   AST_STEP_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == 4'd12 || op_code == 4'd13)) |=> $stable({flag_c, flag_v})); // R10

   AST_STORE_SETS_NZ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && $past(op_code == 4'd1)) |->
         (flag_n == mem_wdata[QW-1] && flag_z == (mem_wdata == '0))); // R3

endmodule

// File: tb/quad_alu_tb.sv
module quad_alu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic        use_mem = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [7:0]  reg_a, reg_x, reg_y, reg_z;
   logic        flag_n, flag_z, flag_c, flag_v;
   logic [31:0] mem_wdata;
   logic        mem_wr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   quad_alu u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .use_mem(use_mem), .mem_rdata(mem_rdata),
      .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .reg_z(reg_z),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
      .mem_wdata(mem_wdata), .mem_wr(mem_wr)
   );

   // fields: op[105:102] use_mem[101] operand[100:69] expQ[68:37]
   //         flags NZCV[36:33] write[32] wdata[31:0]
   localparam int NV = 30;
   localparam logic [105:0] VEC [NV] = '{
      {4'd0, 1'b0, 32'h80000001, 32'h80000001, 4'b1000, 1'b0, 32'h0},
      {4'd1, 1'b0, 32'h00000000, 32'h80000001, 4'b1000, 1'b1, 32'h80000001},
      {4'd0, 1'b0, 32'h00000000, 32'h00000000, 4'b0100, 1'b0, 32'h0},
      {4'd0, 1'b0, 32'h7fffffff, 32'h7fffffff, 4'b0000, 1'b0, 32'h0},
      {4'd2, 1'b0, 32'h7fffffff, 32'h7fffffff, 4'b0110, 1'b0, 32'h0},
      {4'd1, 1'b0, 32'h00000000, 32'h7fffffff, 4'b0010, 1'b1, 32'h7fffffff},
      {4'd3, 1'b0, 32'h00000001, 32'h80000001, 4'b1001, 1'b0, 32'h0},
      {4'd3, 1'b0, 32'h7fffffff, 32'h00000000, 4'b0110, 1'b0, 32'h0},
      {4'd4, 1'b0, 32'h00000001, 32'hffffffff, 4'b1000, 1'b0, 32'h0},
      {4'd4, 1'b0, 32'h7fffffff, 32'h7fffffff, 4'b0011, 1'b0, 32'h0},
      {4'd5, 1'b0, 32'h0000ffff, 32'h0000ffff, 4'b0011, 1'b0, 32'h0},
      {4'd6, 1'b0, 32'hf0000000, 32'hf000ffff, 4'b1011, 1'b0, 32'h0},
      {4'd7, 1'b0, 32'hf000ffff, 32'h00000000, 4'b0111, 1'b0, 32'h0},
      {4'd0, 1'b0, 32'h80000001, 32'h80000001, 4'b1011, 1'b0, 32'h0},
      {4'd8, 1'b0, 32'h00000000, 32'h00000002, 4'b0011, 1'b0, 32'h0},
      {4'd9, 1'b0, 32'h00000000, 32'h00000001, 4'b0001, 1'b0, 32'h0},
      {4'd11, 1'b0, 32'h00000000, 32'h00000000, 4'b0111, 1'b0, 32'h0},
      {4'd11, 1'b0, 32'h00000000, 32'h80000000, 4'b1001, 1'b0, 32'h0},
      {4'd10, 1'b0, 32'h00000000, 32'h00000000, 4'b0111, 1'b0, 32'h0},
      {4'd10, 1'b0, 32'h00000000, 32'h00000001, 4'b0001, 1'b0, 32'h0},
      {4'd13, 1'b0, 32'h00000000, 32'h00000000, 4'b0101, 1'b0, 32'h0},
      {4'd13, 1'b0, 32'h00000000, 32'hffffffff, 4'b1001, 1'b0, 32'h0},
      {4'd12, 1'b0, 32'h00000000, 32'h00000000, 4'b0101, 1'b0, 32'h0},
      {4'd12, 1'b1, 32'h0000ffff, 32'h00000000, 4'b0001, 1'b1, 32'h00010000},
      {4'd8, 1'b1, 32'hc0000000, 32'h00000000, 4'b1011, 1'b1, 32'h80000000},
      {4'd0, 1'b1, 32'h12345678, 32'h12345678, 4'b0011, 1'b0, 32'h0},
      {4'd2, 1'b0, 32'h12345679, 32'h12345678, 4'b1001, 1'b0, 32'h0},
      {4'd14, 1'b0, 32'hffffffff, 32'h12345678, 4'b1001, 1'b0, 32'h0},
      {4'd10, 1'b1, 32'h80000000, 32'h12345678, 4'b0111, 1'b1, 32'h00000000},
      {4'd13, 1'b1, 32'h00000000, 32'h12345678, 4'b1011, 1'b1, 32'hffffffff}
   };

   function automatic string req_of(input logic [3:0] op, input logic um);
      if (um && op >= 4'd8 && op <= 4'd13) return "R11";
      case (op)
         4'd0: return "R2";
         4'd1: return "R3";
         4'd2: return "R4";
         4'd3: return "R5";
         4'd4: return "R6";
         4'd5, 4'd6, 4'd7: return "R7";
         4'd8, 4'd9: return "R8";
         4'd10, 4'd11: return "R9";
         4'd12, 4'd13: return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_state(input string req, input logic [31:0] eq,
                              input logic [3:0] ef, input logic ew,
                              input logic [31:0] ed);
      check(req, "Q", 64'({reg_z, reg_y, reg_x, reg_a}), 64'(eq));
      check(req, "NZCV", 64'({flag_n, flag_z, flag_c, flag_v}), 64'(ef));
      check(req, "write", 64'(mem_wr), 64'(ew));
      if (ew) check(req, "wdata", 64'(mem_wdata), 64'(ed));
   endtask

   task automatic issue(input logic [3:0] op, input logic um, input logic [31:0] m);
      op_valid  = 1'b1;
      op_code   = op;
      use_mem   = um;
      mem_rdata = m;
      @(negedge clk);
      op_valid  = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13: values held in reset
      check_state("R13", 32'h0, 4'b0000, 1'b0, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [105:0] v;
         v = VEC[i];
         issue(v[105:102], v[101], v[100:69]);
         check_state(req_of(v[105:102], v[101]), v[68:37], v[36:33], v[32], v[31:0]);
      end

      // R12: op_valid low with a store pending and varied operands
      for (int k = 0; k < 3; k++) begin
         op_valid  = 1'b0;
         op_code   = 4'(k + 1);
         use_mem   = 1'b1;
         mem_rdata = 32'hdeadbeef;
         @(negedge clk);
         check_state("R12", 32'h12345678, 4'b1011, 1'b0, 32'h0);
      end

      // R1: byte order of the split
      issue(4'd0, 1'b0, 32'ha1b2c3d4);
      check("R1", "reg_a", 64'(reg_a), 64'h00d4);
      check("R1", "reg_x", 64'(reg_x), 64'h00c3);
      check("R1", "reg_y", 64'(reg_y), 64'h00b2);
      check("R1", "reg_z", 64'(reg_z), 64'h00a1);

      // R3: store back-to-back keeps strobe one cycle per store
      issue(4'd1, 1'b0, 32'h0);
      check_state("R3", 32'ha1b2c3d4, 4'b1011, 1'b1, 32'ha1b2c3d4);
      @(negedge clk);
      check("R3", "strobe drop", 64'(mem_wr), 64'h0);

      // R13: reset mid-run clears everything
      rst_n = 1'b0;
      #1;
      check_state("R13", 32'h0, 4'b0000, 1'b0, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule